// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Indicator

This block sits between the two programmable dividers of a frequency synthesizer and the loop filter. The two dividers deliver single-cycle strobes: `ref_stb_i` from the reference divider and `vco_stb_i` from the feedback divider. The block keeps one flag for each strobe and works out which of the two edges arrived first. It then produces three outputs. The first is a 2-bit command for a tri-state charge pump. The second is a push-pull phase line. The third is a pull-down request for an open-drain phase line. All timing is measured in cycles of the reference clock `clk`, and the phase error is the number of cycles between the two edges. A lock indicator watches these error values. Lock drops as soon as an open error reaches the upper threshold. Lock is declared again only after a run of consecutive small errors.

A polarity control swaps the sense of every phase output, to suit a loop whose oscillator gain has either sign. A monitor output shows either the lock indicator or one of the raw divider strobes. A sleep input turns the block off: the charge pump floats, the phase lines go quiet and the indicator reads locked. When sleep is released, the block asks the dividers to resynchronise. It also clips the first error pulse so that the oscillator cannot jump far. A separate active-low input forces only the charge pump into high impedance. The current-range bit passes straight through.

Top module: `phase_cmp_lockdet`

## Requirements
- R1: After reset, the pump command is 2'b00, both phase lines are inactive (`phr_o`=0, `php_pull_o`=0), the lock indicator is 0 and `resync_o` is 0.
- R2: The pump command is 2'b10 (source), 2'b01 (sink), 2'b00 (high impedance) or 2'b11 (both sources on). With `pol_i`=1, a pending reference edge gives 2'b10 and a pending feedback edge gives 2'b01. With `pol_i`=0 the two cases swap. With no edge pending the command is 2'b00.
- R3: With `pol_i`=1, a pending reference edge gives `phr_o`=0 and `php_pull_o`=1, and a pending feedback edge gives `phr_o`=1 and `php_pull_o`=0. With `pol_i`=0 the two cases swap. With no edge pending both are 0.
- R4: When both edges have arrived, both flags clear and the pump command is 2'b11 for DZ_CYCLES cycles (default 1). It then returns to 2'b00 unless a new edge is pending.
- R5: An edge arriving k cycles after the other one gives a comparison with error k. A strobe seen in the cycle after its own edge was taken does not restart the count.
- R6: The lock indicator drops to 0 at the clock edge where a pending error reaches TWU cycles (default 3).
- R7: The lock indicator rises to 1 at the end of the LOCK_RUN-th consecutive comparison (default 3) whose error is at most TWL cycles (default 2). A comparison with an error above TWL resets this run.
- R8: With `mon_sel_i`=0, `mon_o` shows the lock indicator. With `mon_sel_i`=1, it shows `ref_stb_i` when `pol_i`=1 and `vco_stb_i` when `pol_i`=0.
- R9: With `pump_en_n_i`=0, the pump command is 2'b00. The phase lines and the lock indicator are not affected.
- R10: While `sleep_i`=1, the pump command is 2'b00, both phase lines are 0, and the lock indicator reads 1. Strobes are ignored and the detector state is cleared.
- R11: In the first cycle after `sleep_i` falls, `resync_o` is 1 for exactly one cycle and the strobes of that cycle are ignored. Until the next comparison ends, a pending error is shown for at most CLIP_LIMIT cycles (default 4). After that, the pump command is 2'b00 and both phase lines are 0.
- R12: `cs_o` always equals `cs_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_stb_i | input | 1 | Reference divider strobe, one cycle |
| vco_stb_i | input | 1 | Feedback divider strobe, one cycle |
| pol_i | input | 1 | Phase polarity select |
| mon_sel_i | input | 1 | Monitor select: 0 lock, 1 strobe |
| sleep_i | input | 1 | Power-save request, active high |
| pump_en_n_i | input | 1 | Charge pump enable; 0 forces high impedance |
| cs_i | input | 1 | Pump current range bit |
| pump_cmd_o | output | 2 | Charge pump command code |
| phr_o | output | 1 | Push-pull phase line |
| php_pull_o | output | 1 | Open-drain phase line pull-down request |
| mon_o | output | 1 | Lock indicator or strobe monitor |
| resync_o | output | 1 | Divider resynchronise request |
| cs_o | output | 1 | Pump current range bit, passed through |

## Verification
The checker enforces several properties on every cycle. Sleep keeps all outputs quiet. The 2'b11 command appears only inside the dead-zone window. A resync request lasts one cycle and only follows a sleep release. The lock indicator falls only after an error of at least TWU and rises only at the end of a comparison or during sleep. The clipped wake-up pulse never drives the pump. The bench scenarios cover what depends on history: the exact cycle at which lock is gained after a run of small errors, pulse widths for many edge offsets under both polarities, and the monitor selection. These are checked against an independent reference model, cycle by cycle.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    CP_HIZ    = 2'b00,
    CP_SINK   = 2'b01,
    CP_SOURCE = 2'b10,
    CP_BOTH   = 2'b11
  } cp_code_e;

  // Priority: off, then dead-zone window, then source, then sink.
  function automatic cp_code_e cp_encode(input logic off, input logic both,
                                         input logic src, input logic snk);
    if (off)  return CP_HIZ;
    if (both) return CP_BOTH;
    if (src)  return CP_SOURCE;
    if (snk)  return CP_SINK;
    return CP_HIZ;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int ERR_W      = 8,
  parameter int DZ_CYCLES  = 1,
  parameter int CLIP_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_i,
  input  logic             fp_i,
  input  logic             sleep_i,
  output logic             up_q,
  output logic             dn_q,
  output logic             single_o,
  output logic             cmp_done_o,
  output logic [ERR_W-1:0] meas_err_o,
  output logic [ERR_W-1:0] run_err_o,
  output logic [ERR_W-1:0] err_cnt_o,
  output logic             dz_on_o,
  output logic             guard_o,
  output logic             clip_o,
  output logic             hold_o,
  output logic             resync_o
);
  localparam int DZ_W = (DZ_CYCLES < 2) ? 1 : $clog2(DZ_CYCLES + 1);
  localparam logic [DZ_W-1:0]  DZ_LOAD = DZ_W'(DZ_CYCLES);
  localparam logic [ERR_W-1:0] CLIP_V  = ERR_W'(CLIP_LIMIT);

  logic [ERR_W-1:0] err_cnt;
  logic [DZ_W-1:0]  dz_cnt;
  logic             sleep_q;
  logic             guard_q;
  logic             resync_q;
  logic             wake_edge;
  logic             accept;
  logic             up_n, dn_n;

  function automatic logic [ERR_W-1:0] sat_inc(input logic [ERR_W-1:0] x);
    return (x == {ERR_W{1'b1}}) ? x : x + 1'b1;
  endfunction

  // Error of a comparison that would end now: count of pending cycles plus this one.
  function automatic logic [ERR_W-1:0] elapsed(input logic [ERR_W-1:0] cnt,
                                               input logic pend);
    return pend ? sat_inc(cnt) : '0;
  endfunction

  assign wake_edge  = sleep_q & ~sleep_i;
  assign hold_o     = sleep_i | wake_edge;
  assign accept     = ~hold_o;
  assign single_o   = up_q ^ dn_q;
  assign up_n       = up_q | fr_i;
  assign dn_n       = dn_q | fp_i;
  assign cmp_done_o = accept & up_n & dn_n;
  assign meas_err_o = elapsed(err_cnt, single_o);
  assign run_err_o  = sat_inc(err_cnt);
  assign err_cnt_o  = err_cnt;
  assign dz_on_o    = (dz_cnt != '0);
  assign guard_o    = guard_q;
  assign clip_o     = guard_q & single_o & (err_cnt >= CLIP_V);
  assign resync_o   = resync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      err_cnt  <= '0;
      dz_cnt   <= '0;
      guard_q  <= 1'b0;
      resync_q <= 1'b0;
    end else if (hold_o) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      err_cnt  <= '0;
      dz_cnt   <= '0;
      guard_q  <= wake_edge;
      resync_q <= wake_edge;
    end else begin
      resync_q <= 1'b0;
      if (cmp_done_o) begin
        up_q    <= 1'b0;
        dn_q    <= 1'b0;
        err_cnt <= '0;
        dz_cnt  <= DZ_LOAD;
        guard_q <= 1'b0;
      end else begin
        up_q    <= up_n;
        dn_q    <= dn_n;
        err_cnt <= single_o ? sat_inc(err_cnt) : '0;
        dz_cnt  <= dz_on_o ? dz_cnt - 1'b1 : '0;
      end
    end
  end

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet #(
  parameter int ERR_W    = 8,
  parameter int TWU      = 3,
  parameter int TWL      = 2,
  parameter int LOCK_RUN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             cmp_done_i,
  input  logic             single_i,
  input  logic [ERR_W-1:0] meas_err_i,
  input  logic [ERR_W-1:0] run_err_i,
  output logic             lock_q
);
  localparam int GOOD_W = (LOCK_RUN < 2) ? 1 : $clog2(LOCK_RUN + 1);
  localparam logic [ERR_W-1:0]  TWU_V = ERR_W'(TWU);
  localparam logic [ERR_W-1:0]  TWL_V = ERR_W'(TWL);
  localparam logic [GOOD_W-1:0] RUN_V = GOOD_W'(LOCK_RUN);

  logic [GOOD_W-1:0] good_q;
  logic [GOOD_W-1:0] good_nx;

  function automatic logic err_large(input logic [ERR_W-1:0] e);
    return e >= TWU_V;
  endfunction

  function automatic logic err_small(input logic [ERR_W-1:0] e);
    return e <= TWL_V;
  endfunction

  function automatic logic [GOOD_W-1:0] run_inc(input logic [GOOD_W-1:0] g);
    return (g >= RUN_V) ? g : g + 1'b1;
  endfunction

  assign good_nx = run_inc(good_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end else if (hold_i) begin
      lock_q <= 1'b1;
      good_q <= '0;
    end else if (cmp_done_i) begin
      if (err_large(meas_err_i)) begin
        lock_q <= 1'b0;
        good_q <= '0;
      end else if (err_small(meas_err_i)) begin
        good_q <= good_nx;
        if (good_nx >= RUN_V) lock_q <= 1'b1;
      end else begin
        good_q <= '0;
      end
    end else if (single_i && err_large(run_err_i)) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end
  end

endmodule

// File: rtl/pfd_outmux.sv
module pfd_outmux
  import pfd_pkg::*;
(
  input  logic       pol_i,
  input  logic       mon_sel_i,
  input  logic       sleep_i,
  input  logic       pump_en_n_i,
  input  logic       up_q,
  input  logic       dn_q,
  input  logic       dz_on_i,
  input  logic       clip_i,
  input  logic       lock_i,
  input  logic       fr_i,
  input  logic       fp_i,
  output logic [1:0] pump_cmd_o,
  output logic       phr_o,
  output logic       php_pull_o,
  output logic       mon_o
);
  logic     up_only, dn_only;
  logic     src, snk;
  logic     ph_off, cp_off;
  cp_code_e code;

  assign up_only = up_q & ~dn_q;
  assign dn_only = dn_q & ~up_q;
  assign src     = pol_i ? up_only : dn_only;
  assign snk     = pol_i ? dn_only : up_only;
  assign ph_off  = sleep_i | clip_i;
  assign cp_off  = ph_off | ~pump_en_n_i;

  always_comb begin
    code = cp_encode(cp_off, dz_on_i, src, snk);
  end

  assign pump_cmd_o = code;
  assign phr_o      = ~ph_off & snk;
  assign php_pull_o = ~ph_off & src;
  assign mon_o      = mon_sel_i ? (pol_i ? fr_i : fp_i) : (lock_i | sleep_i);

endmodule

// File: rtl/phase_cmp_lockdet.sv
module phase_cmp_lockdet #(
  parameter int ERR_W      = 8,
  parameter int TWU        = 3,
  parameter int TWL        = 2,
  parameter int LOCK_RUN   = 3,
  parameter int DZ_CYCLES  = 1,
  parameter int CLIP_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_stb_i,
  input  logic       vco_stb_i,
  input  logic       pol_i,
  input  logic       mon_sel_i,
  input  logic       sleep_i,
  input  logic       pump_en_n_i,
  input  logic       cs_i,
  output logic [1:0] pump_cmd_o,
  output logic       phr_o,
  output logic       php_pull_o,
  output logic       mon_o,
  output logic       resync_o,
  output logic       cs_o
);
  logic             up_q, dn_q, single, cmp_done, dz_on, guard, clip, hold;
  logic             lock_q;
  logic [ERR_W-1:0] meas_err, run_err, err_cnt;

  pfd_core #(.ERR_W(ERR_W), .DZ_CYCLES(DZ_CYCLES), .CLIP_LIMIT(CLIP_LIMIT)) u_core (
    .clk(clk), .rst_n(rst_n), .fr_i(ref_stb_i), .fp_i(vco_stb_i), .sleep_i(sleep_i),
    .up_q(up_q), .dn_q(dn_q), .single_o(single), .cmp_done_o(cmp_done),
    .meas_err_o(meas_err), .run_err_o(run_err), .err_cnt_o(err_cnt),
    .dz_on_o(dz_on), .guard_o(guard), .clip_o(clip), .hold_o(hold),
    .resync_o(resync_o)
  );

  pfd_lockdet #(.ERR_W(ERR_W), .TWU(TWU), .TWL(TWL), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .cmp_done_i(cmp_done),
    .single_i(single), .meas_err_i(meas_err), .run_err_i(run_err), .lock_q(lock_q)
  );

  pfd_outmux u_out (
    .pol_i(pol_i), .mon_sel_i(mon_sel_i), .sleep_i(sleep_i), .pump_en_n_i(pump_en_n_i),
    .up_q(up_q), .dn_q(dn_q), .dz_on_i(dz_on), .clip_i(clip), .lock_i(lock_q),
    .fr_i(ref_stb_i), .fp_i(vco_stb_i), .pump_cmd_o(pump_cmd_o), .phr_o(phr_o),
    .php_pull_o(php_pull_o), .mon_o(mon_o)
  );

  assign cs_o = cs_i;

endmodule

// File: rtl/phase_cmp_lockdet_chk.sv
module phase_cmp_lockdet_chk #(
  parameter int ERR_W      = 8,
  parameter int TWU        = 3,
  parameter int CLIP_LIMIT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sleep_i,
  input logic             mon_sel_i,
  input logic [1:0]       pump_cmd_o,
  input logic             phr_o,
  input logic             php_pull_o,
  input logic             mon_o,
  input logic             resync_o,
  input logic             dz_on,
  input logic             cmp_done,
  input logic             hold,
  input logic             lock_q,
  input logic             guard,
  input logic [ERR_W-1:0] run_err,
  input logic [ERR_W-1:0] err_cnt
);
  // R10
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (pump_cmd_o == 2'b00) && !phr_o && !php_pull_o && (mon_sel_i || mon_o));

  // R4
  both_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_cmd_o == 2'b11) |-> dz_on);

  // R11
  resync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |=> !resync_o);

  // R11
  resync_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_o |-> ($past(sleep_i, 2) && !$past(sleep_i)));

  // R6
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(run_err) >= ERR_W'(TWU)));

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(cmp_done) || $past(hold)));

  // R11
  clip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard && err_cnt >= ERR_W'(CLIP_LIMIT)) |-> (pump_cmd_o != 2'b10) && (pump_cmd_o != 2'b01));

endmodule

bind phase_cmp_lockdet phase_cmp_lockdet_chk #(
  .ERR_W(ERR_W), .TWU(TWU), .CLIP_LIMIT(CLIP_LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .mon_sel_i(mon_sel_i),
  .pump_cmd_o(pump_cmd_o), .phr_o(phr_o), .php_pull_o(php_pull_o), .mon_o(mon_o),
  .resync_o(resync_o), .dz_on(dz_on), .cmp_done(cmp_done), .hold(hold),
  .lock_q(lock_q), .guard(guard), .run_err(run_err), .err_cnt(err_cnt)
);

// File: tb/tb_phase_cmp_lockdet.sv
`timescale 1ns/1ps
module tb_phase_cmp_lockdet;
  localparam int TWU = 3, TWL = 2, LOCK_RUN = 3, DZ = 1, CLIP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fr = 1'b0, fp = 1'b0, pol = 1'b1, msel = 1'b0, sleep = 1'b0, pen_n = 1'b1, cs = 1'b0;
  logic [1:0] cmd;
  logic phr, php, mon, resync, cs_out;

  always #2 clk = ~clk;

  phase_cmp_lockdet dut (
    .clk(clk), .rst_n(rst_n), .ref_stb_i(fr), .vco_stb_i(fp), .pol_i(pol),
    .mon_sel_i(msel), .sleep_i(sleep), .pump_en_n_i(pen_n), .cs_i(cs),
    .pump_cmd_o(cmd), .phr_o(phr), .php_pull_o(php), .mon_o(mon),
    .resync_o(resync), .cs_o(cs_out)
  );

  int checks = 0, errors = 0;
  bit done = 0, cmp_en = 0;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Reference model built from timestamps of pending edges.
  int m_k, m_up_t, m_dn_t, m_dz, m_good;
  bit m_lock, m_guard, m_resync, m_psleep;

  function automatic int err_of(int k, int up_t, int dn_t);
    if ((up_t >= 0) == (dn_t >= 0)) return 0;
    return (up_t >= 0) ? k - up_t : k - dn_t;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit wake, upa, dna, pend;
    int e;
    if (!rst_n) begin
      m_k = 0; m_up_t = -1; m_dn_t = -1; m_dz = 0; m_good = 0;
      m_lock = 0; m_guard = 0; m_resync = 0; m_psleep = 0;
    end else begin
      m_k++;
      wake = m_psleep && !sleep;
      m_psleep = sleep;
      if (sleep || wake) begin
        m_up_t = -1; m_dn_t = -1; m_dz = 0; m_guard = wake; m_resync = wake;
        m_lock = 1; m_good = 0;
      end else begin
        m_resync = 0;
        upa = (m_up_t >= 0) || fr;
        dna = (m_dn_t >= 0) || fp;
        pend = (m_up_t >= 0) != (m_dn_t >= 0);
        e = err_of(m_k, m_up_t, m_dn_t);
        if (upa && dna) begin
          if (e >= TWU) begin m_lock = 0; m_good = 0; end
          else if (e <= TWL) begin
            if (m_good < LOCK_RUN) m_good++;
            if (m_good >= LOCK_RUN) m_lock = 1;
          end else m_good = 0;
          m_up_t = -1; m_dn_t = -1; m_dz = DZ; m_guard = 0;
        end else begin
          if (pend && e >= TWU) begin m_lock = 0; m_good = 0; end
          if (fr && m_up_t < 0) m_up_t = m_k;
          if (fp && m_dn_t < 0) m_dn_t = m_k;
          if (m_dz > 0) m_dz--;
        end
      end
    end
  end

  always @(posedge clk) begin : compare
    bit up_only, dn_only, src, snk, clip, phoff;
    int el, ecmd;
    #1;
    if (cmp_en && rst_n) begin
      up_only = (m_up_t >= 0) && (m_dn_t < 0);
      dn_only = (m_dn_t >= 0) && (m_up_t < 0);
      el = up_only ? m_k - m_up_t : (dn_only ? m_k - m_dn_t : 0);
      clip = m_guard && (up_only || dn_only) && (el >= CLIP);
      src = pol ? up_only : dn_only;
      snk = pol ? dn_only : up_only;
      phoff = sleep || clip;
      if (phoff || !pen_n) ecmd = 0;
      else if (m_dz > 0) ecmd = 3;
      else if (src) ecmd = 2;
      else if (snk) ecmd = 1;
      else ecmd = 0;
      check("R2", int'(cmd), ecmd, "pump command");
      check("R3", int'(phr), int'(!phoff && snk), "phr");
      check("R3", int'(php), int'(!phoff && src), "php pull");
      check("R8", int'(mon), msel ? int'(pol ? fr : fp) : int'(m_lock || sleep), "monitor");
      check("R11", int'(resync), int'(m_resync), "resync");
      check("R12", int'(cs_out), int'(cs), "cs passthrough");
    end
  end

  task automatic step1(input bit f, input bit p);
    fr = f; fp = p;
    @(negedge clk);
    fr = 0; fp = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", int'(cmd), 0, "pump after reset");
    check("R1", int'(phr) + int'(php), 0, "phase lines after reset");
    check("R1", int'(mon), 0, "lock after reset");
    check("R1", int'(resync), 0, "resync after reset");
    cmp_en = 1;

    // R2 R4 R5 R7: three comparisons with error 1 give lock
    for (int i = 0; i < LOCK_RUN; i++) begin
      step1(1, 0);
      check("R2", int'(cmd), 2, "source on pending reference");
      step1(0, 1);
      check("R4", int'(cmd), 3, "dead-zone pulse");
      check("R7", int'(mon), (i == LOCK_RUN - 1) ? 1 : 0, "lock after run");
      step1(0, 0);
      check("R4", int'(cmd), 0, "idle after window");
    end

    // R6 lock drops once open error reaches TWU
    step1(1, 0);
    step1(0, 0);
    step1(0, 0);
    check("R6", int'(mon), 1, "lock held at error 2");
    step1(0, 0);
    check("R6", int'(mon), 0, "lock dropped at error 3");
    step1(0, 1);

    // R2 R3 polarity swap
    pol = 0;
    step1(0, 1);
    check("R2", int'(cmd), 2, "source on pending feedback, pol 0");
    check("R3", int'(phr), 0, "phr pol 0");
    step1(1, 0);
    pol = 1;

    // R9 pump forced off, phase line still active
    pen_n = 0;
    step1(1, 0);
    check("R9", int'(cmd), 0, "pump forced off");
    check("R9", int'(php), 1, "php unaffected");
    step1(0, 1);
    pen_n = 1;

    // R10 sleep
    sleep = 1;
    step1(1, 0);
    check("R10", int'(cmd), 0, "pump in sleep");
    check("R10", int'(mon), 1, "lock in sleep");
    step1(0, 1);
    // R11 wake: resync, strobes ignored, clipped pulse
    sleep = 0;
    step1(1, 0);
    check("R11", int'(resync), 1, "resync on wake");
    check("R11", int'(cmd), 0, "wake strobe ignored");
    step1(1, 0);
    check("R11", int'(resync), 0, "resync one cycle");
    for (int i = 1; i < CLIP; i++) step1(0, 0);
    check("R11", int'(cmd), 2, "pulse before clip");
    step1(0, 0);
    check("R11", int'(cmd), 0, "pulse clipped");
    step1(0, 1);

    // R8 monitor shows strobe
    msel = 1;
    step1(1, 0);
    step1(0, 1);
    msel = 0;

    // Random segments checked by the model
    for (int seg = 0; seg < 120; seg++) begin
      int per, off, len;
      per = 6 + int'($urandom_range(0, 12));
      off = int'($urandom_range(0, 8)) - 4;
      len = per * (3 + int'($urandom_range(0, 4)));
      pol   = ($urandom_range(0, 3) != 0);
      msel  = ($urandom_range(0, 4) == 0);
      pen_n = ($urandom_range(0, 5) != 0);
      cs    = $urandom_range(0, 1);
      sleep = ($urandom_range(0, 9) == 0);
      for (int c = 0; c < len; c++) begin
        int cf;
        cf = (c - off) % per;
        if (cf < 0) cf += per;
        if ((seg % 7) == 6) step1($urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
        else step1((c % per) == 0, cf == 0);
      end
    end
    sleep = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule